// File: doc/BRIEF.md
# Indexed NVRAM with BCD Time-of-Day Clock

This block models a byte-wide non-volatile memory that also carries a real-time clock. Software reaches it through three byte ports on a small I/O window: an index-low port, an index-high port and a data port. The two index ports together form a 16-bit index. The data port reads or writes the byte that the index selects. After every data write the index returns to zero, so each write sequence starts with a fresh index.

The address map is 8 KB (`MAP_AW` = 13). The top sixteen indices (0x1FF0 to 0x1FFF) belong to the clock, not to RAM. Seven of them return the current time in BCD. The weekday byte also holds two bits that software can write, masked by 0x50. The other clock-area slots read as 0xFF. Only the low `2^RAM_AW` bytes have storage behind them. The time counters hold binary values and step forward on a one-cycle tick. A load interface presets every counter at once. Reset places a few header bytes and the masked weekday bits at known values.

Top module: `nvram_rtc`

## Requirements
- R1: On `io_port`=0 a write replaces index bits 7:0 and leaves bits 15:8 unchanged. On `io_port`=1 a write replaces bits 15:8 and leaves bits 7:0 unchanged.
- R2: On `io_port`=3 a write stores `io_wdata` at the indexed RAM byte, and from the next cycle the index is 0x0000. On `io_port`=3 a read returns the indexed byte without changing the index.
- R3: Whenever `io_port` is 0, 1 or 2, `io_rdata` is 0xFF. A write on `io_port`=2 has no effect.
- R4: A data write to index 0x1FFC stores only bits 6 and 4 (mask 0x50). A read of 0x1FFC returns those stored bits ORed with the weekday (0 to 6). A data write to any other index from 0x1FF0 to 0x1FFF changes nothing.
- R5: Index 0x1FF0 to 0x1FF8 reads as 0xFF. Any index at or above 0x2000 reads as 0xFF. An index from 2^RAM_AW up to 0x1FEF reads as 0xFF, and a write there changes no RAM byte.
- R6: After reset, RAM byte 0x0002 = 0x01, byte 0x0009 = 0x42, the masked 0x1FFC bits = 0x50, the index = 0, and the time is 00:00:00, weekday 0, date 1, month 1, year 00.
- R7: Index 0x1FF9 reads seconds, 0x1FFA reads minutes and 0x1FFB reads hours. Each is two BCD digits with the tens digit in bits 7:4.
- R8: A one-cycle `tick` advances seconds by one. Seconds wrap 59 to 0 and carry into minutes. Minutes wrap 59 to 0 and carry into hours. Hours wrap 23 to 0.
- R9: When hours wrap, the weekday steps forward (6 wraps to 0) and the date steps forward. After the last day of a month the date returns to 1 and the month steps forward. February has 29 days when the year is a multiple of four and 28 days otherwise. December wraps to January and carries into the year, and year 99 wraps to 00.
- R10: `ld_en` loads all seven counters from the `ld_*` inputs in one cycle, and it takes priority over a `tick` in the same cycle.
- R11: Index 0x1FFD reads the date (1 to 31), 0x1FFE reads the month (1 to 12) and 0x1FFF reads the year (00 to 99), each in BCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe for the selected port, one cycle per write |
| io_port | input | 2 | Port select: 0 index low, 1 index high, 2 unused, 3 data |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the selected port (combinational) |
| tick | input | 1 | One-second pulse, one cycle wide |
| ld_en | input | 1 | Load all time counters from the ld_* inputs |
| ld_sec | input | 6 | Seconds to load, binary 0 to 59 |
| ld_min | input | 6 | Minutes to load, binary 0 to 59 |
| ld_hour | input | 5 | Hours to load, binary 0 to 23 |
| ld_wday | input | 3 | Weekday to load, 0 to 6 |
| ld_date | input | 5 | Date to load, 1 to the month length |
| ld_month | input | 4 | Month to load, 1 to 12 |
| ld_year | input | 7 | Year to load, 0 to 99 |

## Verification
The range and calendar assertions on the time counters assume that every load presents a legal time: each field is within its range, and the date does not exceed the length of the loaded month in the loaded year. They also assume that `tick` is a single-cycle pulse. The bench builds every load from its own month-length arithmetic. It keeps `tick` and `ld_en` as one-cycle pulses driven between clock edges. A write is only ever one cycle of `io_wr`, which is what the index-clear and mask properties expect.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

    localparam int unsigned IDX_W    = 16;
    localparam int unsigned IDX_B    = IDX_W / 8;
    localparam logic [7:0]  OPEN_BUS = 8'hFF;
    localparam logic [7:0]  KEEP_MSK = 8'h50;

    typedef enum logic [1:0] {
        PORT_IDX_LO = 2'd0,
        PORT_IDX_HI = 2'd1,
        PORT_SPARE  = 2'd2,
        PORT_DATA   = 2'd3
    } nvr_port_e;

    // low nibble of a clock-area index
    typedef enum logic [3:0] {
        CR_SEC   = 4'h9,
        CR_MIN   = 4'hA,
        CR_HOUR  = 4'hB,
        CR_WDAY  = 4'hC,
        CR_DATE  = 4'hD,
        CR_MONTH = 4'hE,
        CR_YEAR  = 4'hF
    } nvr_creg_e;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] wday;
        logic [4:0] date;
        logic [3:0] month;
        logic [6:0] year;
    } nvr_time_t;

    localparam nvr_time_t TIME_RESET = '{sec: 6'd0, min: 6'd0, hour: 5'd0,
                                         wday: 3'd0, date: 5'd1, month: 4'd1,
                                         year: 7'd0};

    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        logic [7:0] r;
        r = {4'(v / 7'd10), 4'(v % 7'd10)};
        return r;
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
        logic [4:0] n;
        case (m)
            4'd2:                      n = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   n = 5'd30;
            default:                   n = 5'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/nvr_index.sv
module nvr_index
    import nvr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  nvr_port_e        port,
    input  logic [7:0]       wdata,
    output logic [IDX_W-1:0] idx
);

    for (genvar b = 0; b < IDX_B; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                idx[b*8 +: 8] <= 8'h00;
            end else if (wr && port == PORT_DATA) begin
                idx[b*8 +: 8] <= 8'h00;
            end else if (wr && port == nvr_port_e'(b)) begin
                idx[b*8 +: 8] <= wdata;
            end
        end
    end

    // R2: index returns to zero after a data write
    p_idx_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && port == PORT_DATA) |=> (idx == '0));

    // R1: low-byte write keeps the high byte
    p_lo_keep_hi_r1: assert property (@(posedge clk) disable iff (rst)
        (wr && port == PORT_IDX_LO) |=> (idx[7:0] == $past(wdata) && idx[15:8] == $past(idx[15:8])));

    // R1: high-byte write keeps the low byte
    p_hi_keep_lo_r1: assert property (@(posedge clk) disable iff (rst)
        (wr && port == PORT_IDX_HI) |=> (idx[15:8] == $past(wdata) && idx[7:0] == $past(idx[7:0])));

endmodule

// File: rtl/nvr_time.sv
module nvr_time
    import nvr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      ld_en,
    input  nvr_time_t ld_val,
    output nvr_time_t now
);

    nvr_time_t cur, nxt;
    logic      day_end;

    assign day_end = (cur.sec == 6'd59) && (cur.min == 6'd59) && (cur.hour == 5'd23);

    always_comb begin
        nxt = cur;
        if (cur.sec != 6'd59) begin
            nxt.sec = cur.sec + 6'd1;
        end else begin
            nxt.sec = 6'd0;
            if (cur.min != 6'd59) begin
                nxt.min = cur.min + 6'd1;
            end else begin
                nxt.min = 6'd0;
                if (cur.hour != 5'd23) begin
                    nxt.hour = cur.hour + 5'd1;
                end else begin
                    nxt.hour = 5'd0;
                    nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
                    if (cur.date < month_len(cur.month, cur.year)) begin
                        nxt.date = cur.date + 5'd1;
                    end else begin
                        nxt.date = 5'd1;
                        if (cur.month != 4'd12) begin
                            nxt.month = cur.month + 4'd1;
                        end else begin
                            nxt.month = 4'd1;
                            nxt.year  = (cur.year == 7'd99) ? 7'd0 : cur.year + 7'd1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        cur <= TIME_RESET;
        else if (ld_en) cur <= ld_val;
        else if (tick)  cur <= nxt;
    end

    assign now = cur;

    // R10: load wins over tick
    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (cur == $past(ld_val)));

    // R8: seconds step by one below the wrap point
    p_sec_step_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_en && cur.sec != 6'd59) |=> (cur.sec == $past(cur.sec) + 6'd1));

    // R8: seconds wrap at 59
    p_sec_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_en && cur.sec == 6'd59) |=> (cur.sec == 6'd0));

    // R8: no tick, no load, no change
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld_en) |=> $stable(cur));

    // R8: field ranges
    p_hms_range_r8: assert property (@(posedge clk) disable iff (rst)
        (cur.sec <= 6'd59 && cur.min <= 6'd59 && cur.hour <= 5'd23));

    // R9: calendar ranges
    p_cal_range_r9: assert property (@(posedge clk) disable iff (rst)
        (cur.wday <= 3'd6 && cur.date >= 5'd1 && cur.date <= month_len(cur.month, cur.year)
         && cur.month >= 4'd1 && cur.month <= 4'd12 && cur.year <= 7'd99));

    // R9: the date only moves at the end of a day
    p_date_move_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_en && !day_end) |=> (cur.date == $past(cur.date)));

endmodule

// File: rtl/nvr_store.sv
module nvr_store #(
    parameter int unsigned RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RAM_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int unsigned DEPTH = 1 << RAM_AW;
    localparam logic [RAM_AW-1:0] HDR_VER  = RAM_AW'(2);
    localparam logic [RAM_AW-1:0] HDR_ENDN = RAM_AW'(9);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            mem[HDR_VER]  <= 8'h01;
            mem[HDR_ENDN] <= 8'h42;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/nvram_rtc.sv
module nvram_rtc
    import nvr_pkg::*;
#(
    parameter int unsigned RAM_AW = 10,
    parameter int unsigned MAP_AW = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       io_wr,
    input  logic [1:0] io_port,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    input  logic       tick,
    input  logic       ld_en,
    input  logic [5:0] ld_sec,
    input  logic [5:0] ld_min,
    input  logic [4:0] ld_hour,
    input  logic [2:0] ld_wday,
    input  logic [4:0] ld_date,
    input  logic [3:0] ld_month,
    input  logic [6:0] ld_year
);

    localparam logic [IDX_W-1:0] RAM_END  = IDX_W'(1 << RAM_AW);
    localparam logic [IDX_W-1:0] CLK_BASE = IDX_W'((1 << MAP_AW) - 16);
    localparam logic [IDX_W-1:0] KEEP_IDX = CLK_BASE + IDX_W'(CR_WDAY);

    nvr_port_e        port;
    logic [IDX_W-1:0] idx;
    logic             in_ram, in_clk, data_wr;
    logic [7:0]       ram_q, keep_q;
    nvr_time_t        ld_val, now;

    assign port    = nvr_port_e'(io_port);
    assign in_ram  = idx < RAM_END;
    assign in_clk  = idx[IDX_W-1:4] == CLK_BASE[IDX_W-1:4];
    assign data_wr = io_wr && port == PORT_DATA;
    assign ld_val  = '{sec: ld_sec, min: ld_min, hour: ld_hour, wday: ld_wday,
                       date: ld_date, month: ld_month, year: ld_year};

    nvr_index u_index (
        .clk   (clk),
        .rst   (rst),
        .wr    (io_wr),
        .port  (port),
        .wdata (io_wdata),
        .idx   (idx)
    );

    nvr_store #(.RAM_AW(RAM_AW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (data_wr && in_ram),
        .addr  (idx[RAM_AW-1:0]),
        .wdata (io_wdata),
        .rdata (ram_q)
    );

    nvr_time u_time (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .ld_en  (ld_en),
        .ld_val (ld_val),
        .now    (now)
    );

    always_ff @(posedge clk) begin
        if (rst)                             keep_q <= KEEP_MSK;
        else if (data_wr && idx == KEEP_IDX) keep_q <= io_wdata & KEEP_MSK;
    end

    always_comb begin
        io_rdata = OPEN_BUS;
        if (port == PORT_DATA) begin
            if (in_clk) begin
                case (nvr_creg_e'(idx[3:0]))
                    CR_SEC:   io_rdata = bin2bcd({1'b0, now.sec});
                    CR_MIN:   io_rdata = bin2bcd({1'b0, now.min});
                    CR_HOUR:  io_rdata = bin2bcd({2'b0, now.hour});
                    CR_WDAY:  io_rdata = keep_q | {5'b0, now.wday};
                    CR_DATE:  io_rdata = bin2bcd({2'b0, now.date});
                    CR_MONTH: io_rdata = bin2bcd({3'b0, now.month});
                    CR_YEAR:  io_rdata = bin2bcd(now.year);
                    default:  io_rdata = OPEN_BUS;
                endcase
            end else if (in_ram) begin
                io_rdata = ram_q;
            end
        end
    end

    // R3: non-data ports read as open bus
    p_open_ports_r3: assert property (@(posedge clk) disable iff (rst)
        (port != PORT_DATA) |-> (io_rdata == OPEN_BUS));

    // R4: only the masked bits of the weekday byte are kept
    p_keep_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (data_wr && idx == KEEP_IDX) |=> (keep_q == ($past(io_wdata) & KEEP_MSK)));

    // R4: other clock-area writes leave the kept bits alone
    p_clk_wr_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (data_wr && in_clk && idx != KEEP_IDX) |=> $stable(keep_q));

    // R5: beyond the map nothing answers
    p_beyond_map_r5: assert property (@(posedge clk) disable iff (rst)
        (port == PORT_DATA && !in_ram && !in_clk) |-> (io_rdata == OPEN_BUS));

endmodule

// File: tb/sim_nvram_rtc.sv
module sim_nvram_rtc;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_wr = 1'b0;
    logic [1:0] io_port = 2'd0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       tick = 1'b0;
    logic       ld_en = 1'b0;
    logic [5:0] ld_sec = '0;
    logic [5:0] ld_min = '0;
    logic [4:0] ld_hour = '0;
    logic [2:0] ld_wday = '0;
    logic [4:0] ld_date = 5'd1;
    logic [3:0] ld_month = 4'd1;
    logic [6:0] ld_year = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nvram_rtc u0 (.*);

    function automatic int bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic int pat(input int a);
        return (a * 7 + 3) & 8'hFF;
    endfunction

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input int p, input int d);
        @(negedge clk);
        io_wr = 1'b1; io_port = 2'(p); io_wdata = 8'(d);
        @(negedge clk);
        io_wr = 1'b0; io_port = 2'd3;
    endtask

    task automatic set_idx(input int v);
        wr(0, v & 8'hFF);
        wr(1, (v >> 8) & 8'hFF);
    endtask

    task automatic rd(input int p, output int v);
        @(negedge clk);
        io_port = 2'(p);
        #1 v = int'(io_rdata);
    endtask

    task automatic rd_at(input int i, output int v);
        set_idx(i);
        rd(3, v);
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load(input int s, input int mi, input int h, input int w,
                        input int d, input int mo, input int y, input bit with_tick);
        @(negedge clk);
        ld_en = 1'b1; tick = with_tick;
        ld_sec = 6'(s); ld_min = 6'(mi); ld_hour = 5'(h); ld_wday = 3'(w);
        ld_date = 5'(d); ld_month = 4'(mo); ld_year = 7'(y);
        @(negedge clk);
        ld_en = 1'b0; tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3 / R6: reset state
        rd(0, v); check("R3 port0 read", v, 8'hFF);
        rd_at(2, v);      check("R6 header byte 2", v, 8'h01);
        rd_at(9, v);      check("R6 header byte 9", v, 8'h42);
        rd_at('h1FFC, v); check("R6 kept bits", v, 8'h50);
        rd_at('h1FF9, v); check("R6 R7 sec", v, 8'h00);
        rd_at('h1FFA, v); check("R6 R7 min", v, 8'h00);
        rd_at('h1FFB, v); check("R6 R7 hour", v, 8'h00);
        rd_at('h1FFD, v); check("R6 R11 date", v, 8'h01);
        rd_at('h1FFE, v); check("R6 R11 month", v, 8'h01);
        rd_at('h1FFF, v); check("R6 R11 year", v, 8'h00);

        // R1 R2: full RAM sweep
        for (int a = 0; a < 1024; a++) begin
            set_idx(a);
            wr(3, pat(a));
        end
        for (int a = 0; a < 1024; a++) begin
            rd_at(a, v);
            check("R1 R2 ram sweep", v, pat(a));
        end

        // R1: replacing the high byte keeps the low byte
        set_idx('h0334);
        wr(1, 0);
        rd(3, v); check("R1 high byte replaced", v, pat('h34));

        // R2: index clears after a data write
        set_idx(5);
        wr(3, 8'h3C);
        rd(3, v); check("R2 index cleared", v, pat(0));
        set_idx(5);
        rd(3, v); check("R2 read", v, 8'h3C);
        rd(3, v); check("R2 read keeps index", v, 8'h3C);
        wr(3, 8'h77);
        rd_at(5, v); check("R2 write after reads", v, 8'h77);

        // R3: non-data ports
        set_idx(6);
        rd(0, v); check("R3 port0", v, 8'hFF);
        rd(1, v); check("R3 port1", v, 8'hFF);
        rd(2, v); check("R3 port2", v, 8'hFF);
        wr(2, 8'h00);
        rd(3, v); check("R3 spare write no effect", v, pat(6));

        // R5: unmapped reads and writes
        for (int i = 'h1FF0; i <= 'h1FF8; i++) begin
            rd_at(i, v); check("R5 clock area", v, 8'hFF);
        end
        rd_at('h2000, v); check("R5 0x2000", v, 8'hFF);
        rd_at('hFFFF, v); check("R5 0xFFFF", v, 8'hFF);
        rd_at('h1FEF, v); check("R5 0x1FEF", v, 8'hFF);
        rd_at('h0400, v); check("R5 past ram", v, 8'hFF);
        set_idx('h0400); wr(3, 8'h12);
        rd_at('h0400, v); check("R5 past ram write", v, 8'hFF);
        rd_at(0, v);      check("R5 no alias", v, pat(0));
        set_idx('h2009); wr(3, 8'h12);
        rd_at(9, v);      check("R5 high no alias", v, pat(9));

        // R4: masked weekday byte and ignored clock writes
        load(7, 8, 9, 3, 10, 5, 21, 1'b0);
        set_idx('h1FFC); wr(3, 8'hFF);
        rd_at('h1FFC, v); check("R4 mask ff", v, 8'h53);
        set_idx('h1FFC); wr(3, 8'h0F);
        rd_at('h1FFC, v); check("R4 mask 0f", v, 8'h03);
        set_idx('h1FFC); wr(3, 8'h10);
        rd_at('h1FFC, v); check("R4 mask 10", v, 8'h13);
        set_idx('h1FF9); wr(3, 8'h33);
        rd_at('h1FF9, v); check("R4 sec write ignored", v, 8'h07);
        set_idx('h1FFF); wr(3, 8'h44);
        rd_at('h1FFF, v); check("R4 year write ignored", v, 8'h21);

        // R8: one hour of ticks
        load(0, 0, 0, 0, 1, 1, 0, 1'b0);
        set_idx('h1FF9);
        for (int t = 1; t <= 3600; t++) begin
            do_tick();
            rd(3, v); check("R8 R7 seconds", v, bcd(t % 60));
        end
        rd_at('h1FFA, v); check("R8 minutes after hour", v, 8'h00);
        rd_at('h1FFB, v); check("R8 hours after hour", v, 8'h01);
        load(50, 59, 12, 0, 1, 1, 0, 1'b0);
        set_idx('h1FFA);
        for (int t = 0; t < 10; t++) do_tick();
        rd(3, v); check("R8 minute carry", v, 8'h00);
        rd_at('h1FFB, v); check("R8 hour carry", v, 8'h13);

        // R9 R11: month ends across four years plus year 99
        for (int y = 0; y < 5; y++) begin
            int yy;
            yy = (y == 4) ? 99 : y;
            for (int m = 1; m <= 12; m++) begin
                load(59, 59, 23, m % 7, mdays(m, yy), m, yy, 1'b0);
                do_tick();
                rd_at('h1FFD, v); check("R9 R11 date wrap", v, 8'h01);
                rd_at('h1FFE, v); check("R9 R11 month step", v, bcd(m == 12 ? 1 : m + 1));
                rd_at('h1FFF, v); check("R9 R11 year", v, bcd(m == 12 ? (yy + 1) % 100 : yy));
                rd_at('h1FFC, v); check("R9 weekday", v, 8'h10 | ((m % 7 + 1) % 7));
                rd_at('h1FFB, v); check("R9 hour wrap", v, 8'h00);
                load(59, 59, 23, 0, mdays(m, yy) - 1, m, yy, 1'b0);
                do_tick();
                rd_at('h1FFD, v); check("R9 R11 last day", v, bcd(mdays(m, yy)));
            end
        end

        // R10: load takes priority over a same-cycle tick
        load(45, 30, 17, 4, 28, 2, 24, 1'b1);
        rd_at('h1FF9, v); check("R10 sec", v, 8'h45);
        rd_at('h1FFA, v); check("R10 min", v, 8'h30);
        rd_at('h1FFB, v); check("R10 hour", v, 8'h17);
        rd_at('h1FFD, v); check("R10 date", v, 8'h28);
        rd_at('h1FFE, v); check("R10 month", v, 8'h02);
        rd_at('h1FFF, v); check("R10 year", v, 8'h24);
        rd_at('h1FFC, v); check("R10 weekday", v, 8'h14);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule